// File: doc/BRIEF.md
# Serial Byte-Memory Slave with Timed Programming

This block is the two-wire serial slave interface of a 256-byte non-volatile memory. It samples the clock and data lines of an open-drain serial bus with the system clock. From the sampled lines it detects bus start and stop conditions and matches a 7-bit device address. It then either takes in one byte to program or streams stored bytes back to the bus master. The only data path is the bus itself. The slave never holds the clock low, so it applies no back-pressure: a transfer can only be accepted (ACK) or refused (NACK, SDA left released). Inside the block, a transfer is always taken in one step when its byte completes.

A write transfer carries a word address and one data byte. The stop condition that closes it starts a programming window whose length is a number of system clocks. While the window runs, the device ignores every request. The byte enters the storage array when the window ends. A read transfer streams bytes from an 8-bit pointer that wraps from 255 to 0. The master's acknowledge decides whether streaming continues. The block drives the bus through an active-high pull-down request, and the pad around it performs the open-drain function.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the pull-down request is low and the slave is idle and not programming.
- R2: A START (SDA falling while SCL is high) restarts byte framing at any point. A STOP (SDA rising while SCL is high) returns the slave to idle. Both lines pass through a two-flop synchronizer before use.
- R3: The first byte after START is the device address, MSB first, followed by a direction bit (0 = write, 1 = read). The address 1010000 (0x50) is answered by holding SDA low for the ninth clock. Any other address gets no acknowledge, and SDA stays released until the next START.
- R4: In a write, the byte after the address is loaded into the word pointer and acknowledged. The byte after that is the data byte and is also acknowledged. Any further byte in the same transfer is not acknowledged.
- R5: A STOP after an acknowledged data byte starts a busy window of PROG_CYCLES system clocks. During the window no device address is acknowledged. The byte is written at the pointer when the window ends, and the pointer keeps the word address.
- R6: A START that arrives after the data byte but before the STOP abandons the write: the storage is unchanged and no busy window runs. A STOP that follows only a word address sets the pointer and starts no busy window.
- R7: In a read, the slave sends 8 bits MSB first from the pointer and changes SDA only while SCL is low. It releases SDA for the ninth clock. The pointer advances by one after each byte and wraps from 255 to 0.
- R8: If the master acknowledges (SDA low on the ninth clock), the next byte follows. If it does not, the slave keeps SDA released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level from the pad |
| sda_in | input | 1 | Serial data line level from the pad |
| sda_pull_o | output | 1 | 1 = pull SDA low; 0 = release |

## Verification
Two functions can meet in the same short interval: the STOP that arms the programming window, and a new address byte whose acknowledge decision falls inside that window. The bench sends an address probe straight after each write's STOP, so the ninth clock lands well before the window ends. It expects a refusal there and an acknowledge once the window has passed. A repeated START placed against a pending write is judged by reading the location back after a full window time.

// File: rtl/i2c_mem_slave_pkg.sv
package i2c_mem_slave_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_DEVACK,
    ST_WADR,
    ST_WADRACK,
    ST_WDATA,
    ST_WDATAACK,
    ST_RDATA,
    ST_RDACK
  } slv_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_in;
          sda_ff <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
          sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_ff[SYNC_STAGES-1];
  assign sda_lvl   = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int PROG_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (launch && cnt == '0)
      cnt <= CW'(PROG_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         PROG_CYCLES = 250000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull_o
);
  localparam int AW = BYTE_W;
  localparam int BW = $clog2(BYTE_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic busy, mem_we;
  logic [BYTE_W-1:0] rd_data;

  slv_state_e        st;
  logic [BW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              byte_full;
  logic              rw_q;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] wr_data;
  logic              wr_pend;
  logic              pull;
  logic              mst_ack;

  bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(stop_det & wr_pend),
    .busy(busy), .done(mem_we)
  );

  byte_store #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(wr_data),
    .raddr(ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_full <= 1'b0;
      rw_q      <= 1'b0;
      ptr       <= '0;
      wr_data   <= '0;
      wr_pend   <= 1'b0;
      pull      <= 1'b0;
      mst_ack   <= 1'b0;
    end else if (start_det) begin
      st        <= ST_DEVADR;
      bit_cnt   <= '0;
      byte_full <= 1'b0;
      pull      <= 1'b0;
      wr_pend   <= 1'b0;
    end else if (stop_det) begin
      st        <= ST_IDLE;
      byte_full <= 1'b0;
      pull      <= 1'b0;
      wr_pend   <= 1'b0;
    end else begin
      case (st)
        ST_DEVADR, ST_WADR, ST_WDATA: begin
          if (scl_rise && !byte_full) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
            bit_cnt <= bit_cnt + BW'(1);
            if (bit_cnt == BW'(BYTE_W - 1)) byte_full <= 1'b1;
          end else if (scl_fall && byte_full) begin
            byte_full <= 1'b0;
            if (st == ST_DEVADR) begin
              if (shreg[BYTE_W-1:1] == DEV_ADDR && !busy) begin
                pull <= 1'b1;
                rw_q <= shreg[0];
                st   <= ST_DEVACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_WADR) begin
              ptr  <= shreg;
              pull <= 1'b1;
              st   <= ST_WADRACK;
            end else begin
              wr_data <= shreg;
              pull    <= 1'b1;
              st      <= ST_WDATAACK;
            end
          end
        end
        ST_DEVACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              shreg <= rd_data;
              pull  <= ~rd_data[BYTE_W-1];
              st    <= ST_RDATA;
            end else begin
              pull <= 1'b0;
              st   <= ST_WADR;
            end
          end
        end
        ST_WADRACK: begin
          if (scl_fall) begin
            pull    <= 1'b0;
            bit_cnt <= '0;
            st      <= ST_WDATA;
          end
        end
        ST_WDATAACK: begin
          if (scl_fall) begin
            pull    <= 1'b0;
            wr_pend <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == BW'(BYTE_W - 1)) begin
              pull <= 1'b0;
              ptr  <= ptr + AW'(1);
              st   <= ST_RDACK;
            end else begin
              shreg   <= {shreg[BYTE_W-2:0], 1'b0};
              pull    <= ~shreg[BYTE_W-2];
              bit_cnt <= bit_cnt + BW'(1);
            end
          end
        end
        ST_RDACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mst_ack) begin
              bit_cnt <= '0;
              shreg   <= rd_data;
              pull    <= ~rd_data[BYTE_W-1];
              st      <= ST_RDATA;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull_o = pull;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_slave_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_pull_o,
  input logic       busy,
  input logic       mem_we,
  input logic [7:0] ptr,
  input slv_state_e st
);
  // R7: SDA moves only while the synchronized SCL is low (bus conditions aside)
  assert_sda_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

  // R5: nothing is driven while programming
  assert_busy_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);

  // R5: a busy window opens only on a STOP
  assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  // R5: the storage write closes the window
  assert_store_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !busy);

  // R7: pointer steps by exactly one in reads, wrapping mod 256
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr) && $past(st) == ST_RDATA) |-> ptr == $past(ptr) + 8'd1);

  // R3: idle slave never holds SDA
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> !sda_pull_o);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .sda_pull_o(sda_pull_o), .busy(busy),
  .mem_we(mem_we), .ptr(ptr), .st(st)
);

// File: tb/tb_i2c_mem_slave.sv
`timescale 1ns/1ps
module tb_i2c_mem_slave;
  localparam int PROG = 300;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_pull;
  logic sda_bus;
  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  int   model [256];

  always #10 clk = ~clk;
  assign sda_bus = ~(m_low | sda_pull);

  i2c_mem_slave #(.DEV_ADDR(7'h50), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_pull_o(sda_pull)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic m_stop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic bit_cycle(input bit drive_low, output bit sampled);
    m_low = drive_low; tick(Q);
    scl = 1'b1;        tick(Q);
    sampled = sda_bus; tick(Q);
    scl = 1'b0;        tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_cycle(!b[i], s);
    bit_cycle(1'b0, s);
    ack = !s;
  endtask

  task automatic read_byte(input bit send_ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b0, s);
      d[i] = s;
    end
    bit_cycle(send_ack, s);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit a1, a2, a3;
    logic [7:0] d;
    int wa, last_wa;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1: reset state
    check(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
    check(sda_bus == 1'b1, "R1 bus released", sda_bus, 1);

    // R3 / R2: sweep all device addresses, write direction
    for (int a = 0; a < 128; a++) begin
      m_start();
      write_byte({a[6:0], 1'b0}, a1);
      check(a1 == (a == 'h50), "R3 address ack", a1, (a == 'h50));
      if (a != 'h50) begin
        write_byte(8'h00, a2);
        check(!a2, "R3 released after mismatch", a2, 0);
      end
      m_stop();
    end

    // R4 / R5: byte writes with busy probes
    last_wa = 0;
    for (int i = 0; i < 16; i++) begin
      wa = (i < 4) ? ((254 + i) & 255) : ((i * 29 + 7) & 255);
      m_start();
      write_byte(8'hA0, a1);
      write_byte(wa[7:0], a2);
      write_byte(8'((wa * 7 + 13) & 255), a3);
      check(a1 && a2 && a3, "R4 write acks", {a1, a2, a3}, 7);
      if (i == 5) begin
        write_byte(8'h33, a1);
        check(!a1, "R4 extra byte refused", a1, 0);
      end
      m_stop();
      model[wa] = (wa * 7 + 13) & 255;
      last_wa = wa;
      m_start();
      write_byte(8'hA0, a1);
      check(!a1, "R5 busy refuses address", a1, 0);
      m_stop();
      tick(PROG + 50);
      if (i == 0) begin
        m_start();
        write_byte(8'hA0, a1);
        check(a1, "R5 ack after window", a1, 1);
        m_stop();
      end
    end

    // R5: pointer keeps the word address; current read returns the written byte
    m_start();
    write_byte(8'hA1, a1);
    read_byte(1'b0, d);
    m_stop();
    check(a1 && d == 8'(model[last_wa]), "R5 current read", d, model[last_wa]);

    // R7 / R8 / R2: random sequential read across the 255->0 wrap
    m_start();
    write_byte(8'hA0, a1);
    write_byte(8'd254, a2);
    m_start();
    write_byte(8'hA1, a3);
    check(a1 && a2 && a3, "R2 repeated start framing", {a1, a2, a3}, 7);
    read_byte(1'b1, d);
    check(d == 8'(model[254]), "R7 read 254", d, model[254]);
    read_byte(1'b1, d);
    check(d == 8'(model[255]), "R7 read 255", d, model[255]);
    read_byte(1'b0, d);
    check(d == 8'(model[0]), "R7 wrap to 0", d, model[0]);
    read_byte(1'b0, d);
    check(d == 8'hFF, "R8 released after nack", d, 8'hFF);
    m_stop();
    m_start();
    write_byte(8'hA1, a1);
    read_byte(1'b0, d);
    m_stop();
    check(d == 8'(model[1]), "R8 pointer after nack", d, model[1]);

    // R6: abandoned write via repeated START
    wa = (6 * 29 + 7) & 255;
    m_start();
    write_byte(8'hA0, a1);
    write_byte(wa[7:0], a1);
    write_byte(8'(~model[wa]), a1);
    m_start();
    write_byte(8'hA0, a2);
    check(a2, "R6 no busy after abandon", a2, 1);
    m_stop();
    tick(PROG + 50);
    m_start();
    write_byte(8'hA1, a1);
    read_byte(1'b0, d);
    m_stop();
    check(d == 8'(model[wa]), "R6 storage unchanged", d, model[wa]);

    // R6: STOP after only a word address sets the pointer, no busy
    m_start();
    write_byte(8'hA0, a1);
    write_byte(8'd255, a1);
    m_stop();
    m_start();
    write_byte(8'hA1, a2);
    check(a2, "R6 no busy after address-only write", a2, 1);
    read_byte(1'b1, d);
    check(d == 8'(model[255]), "R6 pointer set by address-only", d, model[255]);
    read_byte(1'b0, d);
    check(d == 8'(model[0]), "R7 wrap in second read", d, model[0]);
    m_stop();
    tick(10);
    check(sda_pull == 1'b0, "R2 idle after stop", sda_pull, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule